// File: doc/BRIEF.md
# Dual-Channel Cascadable Pulse Generator

This block produces two continuous rectangular waveforms whose period and duty cycle are set by software. Each channel runs a down counter. One reload value sets the length of the low phase, and a second reload value sets the length of the high phase. Every phase lasts the reload value plus one periods of the channel's count clock. The count clock is either the system clock divided by a power of two from 1 to 16, or a single-cycle pulse from an external timebase.

Software configures the block through a simple register write port. Enabling a channel starts its waveform with the low phase. Clearing the enable stops the counter and holds the output low. The two channels can also work together in two ways:

- In the chained arrangement, channel 0 acts as a prescaler and channel 1 counts once for each completed low-plus-high cycle of channel 0.
- In the wide arrangement, both channels form one generator whose low and high reloads are 16 bits wide.

Top module: `pgen_pair`

## Requirements
- R1: After reset, both outputs are low, both enables are clear, all reloads are zero and the arrangement is split (two independent channels).
- R2: A write that sets a channel's enable (bit 0 of that channel's control register) takes effect one clock later, when the channel loads its low reload. The output is low from that point, so after the write the output stays low for L+2 clock periods when the count clock is undivided.
- R3: Clearing a channel's enable forces its output low from the second clock after the write, and the output then stays low.
- R4: While enabled, the output repeats low for (L+1) and high for (H+1) count-clock periods without stopping.
- R5: The count-clock select field is bits 3:1 of a control register. Codes 0 to 4 divide the clock by 1, 2, 4, 8 and 16, using a 4-bit counter that is zero after reset and counts every clock; code k ticks when its low k bits are all ones. Codes 5 to 7 use the timebase input.
- R6: Write addresses: 0 channel-0 low reload, 1 channel-0 high reload, 2 channel-1 low reload, 3 channel-1 high reload, 4 channel-0 control, 5 channel-1 control, 6 joint enable (data bit 0 written to both enables at once). Address 7 is ignored.
- R7: A reload value written during a phase is used only at the next phase switch. The phase already in progress keeps its length.
- R8: The arrangement field is bits 5:4 of the channel-1 control register. Code 01 selects chained: channel 1 advances one count for each full cycle of channel 0.
- R9: In the chained arrangement, channel 1 stays idle with its output low while channel 0's enable is clear, even if channel 1's own enable is set.
- R10: Code 11 selects wide. The 16-bit low reload is {channel-1 low, channel-0 low} and the 16-bit high reload is {channel-1 high, channel-0 high}. The count clock is channel 0's. The generator runs only while both enables are set. Both outputs carry the combined waveform. Codes 00 and 10 select split.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W (8) | Register write data |
| tb_tick | input | 1 | One-cycle pulse from the external timebase |
| pulse0 | output | 1 | Channel 0 waveform |
| pulse1 | output | 1 | Channel 1 waveform, or the combined waveform in wide arrangement |

## Verification
The hardest situation to reach is a reload that changes while a phase is in progress. The write has to land inside a specific phase, after it has started. The stimulus waits at the ports for the rising edge of channel 1. It then writes a shorter high reload on that same cycle and measures the length of the current high phase and of the following one. The chained arrangement with channel 0 stopped is reached by programming the arrangement and channel 1's enable first. The bench then observes channel 1 for a long window before channel 0 is started.

// File: rtl/pgen_pkg.sv
// Shared constants for the pulse generator: register addresses, field
// positions and arrangement codes. Assumes a data width of at least 6 bits.
package pgen_pkg;
    localparam int ADDR_W   = 3;
    localparam int SEL_W    = 3;
    localparam int DIV_LOG  = 4;   // largest division is 2**DIV_LOG
    localparam int EN_BIT   = 0;
    localparam int SEL_LSB  = 1;
    localparam int MODE_LSB = 4;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'b00,
        MODE_CHAIN = 2'b01,
        MODE_ALT   = 2'b10,
        MODE_WIDE  = 2'b11
    } pgen_mode_e;

    localparam logic [ADDR_W-1:0] REG_LO0   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_HI0   = 3'd1;
    localparam logic [ADDR_W-1:0] REG_LO1   = 3'd2;
    localparam logic [ADDR_W-1:0] REG_HI1   = 3'd3;
    localparam logic [ADDR_W-1:0] REG_CTL0  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_CTL1  = 3'd5;
    localparam logic [ADDR_W-1:0] REG_JOINT = 3'd6;
endpackage

// File: rtl/pgen_regs.sv
// Configuration registers of the pulse generator. Holds the four reload
// bytes, two enables, two clock selects and the arrangement code.
// Assumes W >= MODE_LSB+2 so the arrangement field fits in a control byte.
module pgen_regs
    import pgen_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [W-1:0]                wr_data,
    output logic [1:0][W-1:0]           lo,
    output logic [1:0][W-1:0]           hi,
    output logic [1:0]                  en,
    output logic [1:0][SEL_W-1:0]       sel,
    output pgen_mode_e                  mode
);

    // Register update from the write port; unknown addresses are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo   <= '0;
            hi   <= '0;
            en   <= '0;
            sel  <= '0;
            mode <= MODE_SPLIT;
        end else if (wr_en) begin
            case (wr_addr)
                REG_LO0:  lo[0] <= wr_data;
                REG_HI0:  hi[0] <= wr_data;
                REG_LO1:  lo[1] <= wr_data;
                REG_HI1:  hi[1] <= wr_data;
                REG_CTL0: begin
                    en[0]  <= wr_data[EN_BIT];
                    sel[0] <= wr_data[SEL_LSB +: SEL_W];
                end
                REG_CTL1: begin
                    en[1]  <= wr_data[EN_BIT];
                    sel[1] <= wr_data[SEL_LSB +: SEL_W];
                    mode   <= pgen_mode_e'(wr_data[MODE_LSB +: 2]);
                end
                REG_JOINT: en <= {2{wr_data[EN_BIT]}};
                default: ;
            endcase
        end
    end

    // R6: a joint write sets both enables to the same value on the next cycle.
    a_r6_joint_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_JOINT) |=> (en[0] == en[1]));

endmodule

// File: rtl/pgen_tickgen.sv
// Count-clock enables. A free-running divider counter, zero after reset,
// provides power-of-two ticks; each channel picks one of them or the
// external timebase pulse. Assumes tb_tick is one clock wide per event.
module pgen_tickgen
    import pgen_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tb_tick,
    input  logic [NCH-1:0][SEL_W-1:0]   sel,
    output logic [NCH-1:0]              tick
);
    localparam logic [SEL_W-1:0] LAST_DIV_SEL = SEL_W'(DIV_LOG);

    logic [DIV_LOG-1:0] div_cnt;
    logic [DIV_LOG:0]   pow_tick;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    assign pow_tick[0] = 1'b1;
    for (genvar k = 1; k <= DIV_LOG; k++) begin : g_pow
        assign pow_tick[k] = &div_cnt[k-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        // Per-channel selection between divided clock and timebase.
        always_comb begin
            if (sel[c] > LAST_DIV_SEL) tick[c] = tb_tick;
            else                       tick[c] = pow_tick[sel[c]];
        end
    end

endmodule

// File: rtl/pgen_chan.sv
// One pulse channel. While enabled, a down counter alternates between the
// low reload and the high reload, each phase lasting reload+1 ticks, and
// the output follows the phase. Starts in the low phase; disabled means
// output low. cycle_done flags the tick that ends a high phase.
module pgen_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] rld_lo,
    input  logic [W-1:0] rld_hi,
    output logic         pulse_out,
    output logic         cycle_done
);
    logic         running;
    logic [W-1:0] cnt;
    logic         at_zero;

    assign at_zero    = (cnt == '0);
    assign cycle_done = running && tick && at_zero && pulse_out;

    // Phase counter: start, count down, swap phase and reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            running   <= 1'b0;
            pulse_out <= 1'b0;
            cnt       <= '0;
        end else if (!running) begin
            running   <= 1'b1;
            pulse_out <= 1'b0;
            cnt       <= rld_lo;
        end else if (tick) begin
            if (at_zero) begin
                pulse_out <= ~pulse_out;
                cnt       <= pulse_out ? rld_lo : rld_hi;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R3: a cleared enable leaves the output low on the next cycle.
    a_r3_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse_out);

    // R2: every start of counting begins in the low phase.
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !pulse_out);

    // R4: the output only changes when the counter expires on a tick.
    a_r4_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && !(tick && at_zero)) |=> $stable(pulse_out));

endmodule

// File: rtl/pgen_pair.sv
// Top of the two-channel pulse generator. Decodes the arrangement and
// routes enables, reloads and ticks: split (independent), chained
// (channel 0 cycles clock channel 1) or wide (one 16-bit generator built
// on channel 0's counter, mirrored on both outputs).
module pgen_pair
    import pgen_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              tb_tick,
    output logic              pulse0,
    output logic              pulse1
);
    localparam int WW = 2 * W;

    logic [1:0][W-1:0]     lo;
    logic [1:0][W-1:0]     hi;
    logic [1:0]            en;
    logic [1:0][SEL_W-1:0] sel;
    pgen_mode_e            mode;
    logic [1:0]            base_tick;
    logic                  wide;
    logic                  chain;
    logic                  en0_eff;
    logic                  en1_eff;
    logic                  tick1_eff;
    logic [WW-1:0]         lo0_eff;
    logic [WW-1:0]         hi0_eff;
    logic                  out0;
    logic                  out1;
    logic                  done0;
    logic                  done1_unused;

    pgen_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lo      (lo),
        .hi      (hi),
        .en      (en),
        .sel     (sel),
        .mode    (mode)
    );

    pgen_tickgen #(.NCH(2)) u_ticks (
        .clk     (clk),
        .rst_n   (rst_n),
        .tb_tick (tb_tick),
        .sel     (sel),
        .tick    (base_tick)
    );

    // Arrangement decode and routing of enables, reloads and ticks.
    always_comb begin
        wide      = (mode == MODE_WIDE);
        chain     = (mode == MODE_CHAIN);
        en0_eff   = wide ? (en[0] && en[1]) : en[0];
        en1_eff   = wide ? 1'b0 : (chain ? (en[1] && en[0]) : en[1]);
        tick1_eff = chain ? done0 : base_tick[1];
        lo0_eff   = wide ? {lo[1], lo[0]} : {{W{1'b0}}, lo[0]};
        hi0_eff   = wide ? {hi[1], hi[0]} : {{W{1'b0}}, hi[0]};
    end

    pgen_chan #(.W(WW)) u_ch0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en0_eff),
        .tick       (base_tick[0]),
        .rld_lo     (lo0_eff),
        .rld_hi     (hi0_eff),
        .pulse_out  (out0),
        .cycle_done (done0)
    );

    pgen_chan #(.W(W)) u_ch1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en1_eff),
        .tick       (tick1_eff),
        .rld_lo     (lo[1]),
        .rld_hi     (hi[1]),
        .pulse_out  (out1),
        .cycle_done (done1_unused)
    );

    assign pulse0 = out0;
    assign pulse1 = wide ? out0 : out1;

    // R9: chained channel 1 is low whenever channel 0's enable is clear.
    a_r9_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && !en[0]) |=> !pulse1);

    // R10: the wide generator stays low unless both enables are set.
    a_r10_wide_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !(en[0] && en[1])) |=> !pulse0);

endmodule

// File: tb/pgen_pair_test.sv
`timescale 1ns/1ps
module pgen_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tb_tick = 1'b0;
    logic       pulse0;
    logic       pulse1;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit tb_on = 1'b0;
    int tb_cnt = 0;

    // reference model state
    int m_lo[2], m_hi[2], m_en[2], m_sel[2], m_mode, m_div;
    int m_run[2], m_high[2], m_cnt[2];
    bit m_out0, m_out1;

    always #10 clk = ~clk;

    pgen_pair uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .tb_tick(tb_tick), .pulse0(pulse0), .pulse1(pulse1));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit mtick(input int c);
        if (m_sel[c] >= 5) return tb_tick;
        return (m_div % (1 << m_sel[c])) == ((1 << m_sel[c]) - 1);
    endfunction

    task automatic mstep(input int c, input bit en, input bit tk, input int l, input int h);
        if (!en) begin
            m_run[c] = 0; m_high[c] = 0; m_cnt[c] = 0;
        end else if (!m_run[c]) begin
            m_run[c] = 1; m_high[c] = 0; m_cnt[c] = l;
        end else if (tk) begin
            if (m_cnt[c] == 0) begin
                m_cnt[c] = m_high[c] ? l : h;
                m_high[c] = !m_high[c];
            end else m_cnt[c]--;
        end
    endtask

    // Behavioural model advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_lo[c] = 0; m_hi[c] = 0; m_en[c] = 0; m_sel[c] = 0;
                m_run[c] = 0; m_high[c] = 0; m_cnt[c] = 0;
            end
            m_mode = 0; m_div = 0;
        end else begin
            bit wide, chain, t0, t1, d0, e0, e1;
            int l0, h0;
            wide  = (m_mode == 3);
            chain = (m_mode == 1);
            t0 = mtick(0);
            t1 = mtick(1);
            d0 = m_run[0] && t0 && m_cnt[0] == 0 && m_high[0];
            l0 = wide ? m_lo[1] * 256 + m_lo[0] : m_lo[0];
            h0 = wide ? m_hi[1] * 256 + m_hi[0] : m_hi[0];
            e0 = wide ? (m_en[0] && m_en[1]) : m_en[0];
            e1 = wide ? 0 : (chain ? (m_en[1] && m_en[0]) : m_en[1]);
            mstep(0, e0, t0, l0, h0);
            mstep(1, e1, chain ? d0 : t1, m_lo[1], m_hi[1]);
            if (wr_en) begin
                case (wr_addr)
                    0: m_lo[0] = wr_data;
                    1: m_hi[0] = wr_data;
                    2: m_lo[1] = wr_data;
                    3: m_hi[1] = wr_data;
                    4: begin m_en[0] = wr_data[0]; m_sel[0] = wr_data[3:1]; end
                    5: begin m_en[1] = wr_data[0]; m_sel[1] = wr_data[3:1]; m_mode = wr_data[5:4]; end
                    6: begin m_en[0] = wr_data[0]; m_en[1] = wr_data[0]; end
                    default: ;
                endcase
            end
            m_div = (m_div + 1) % 16;
        end
        m_out0 = m_high[0];
        m_out1 = (m_mode == 3) ? m_high[0] : m_high[1];
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(pulse0 == m_out0, {cur_req, " pulse0 vs model"}, pulse0, m_out0);
            check(pulse1 == m_out1, {cur_req, " pulse1 vs model"}, pulse1, m_out1);
        end
    end

    // Timebase pulse every third cycle while enabled.
    always @(negedge clk) begin
        tb_tick <= tb_on && (tb_cnt % 3 == 0);
        tb_cnt  <= tb_cnt + 1;
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit pin(input int ch);
        return ch == 0 ? pulse0 : pulse1;
    endfunction

    task automatic wait_level(input int ch, input bit v);
        int n = 0;
        while (pin(ch) != v && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic run_len(input int ch, input bit v, output int n);
        n = 0;
        while (pin(ch) == v && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic low_window(input int ch, input int len, input string req);
        int highs = 0;
        for (int i = 0; i < len; i++) begin
            if (pin(ch)) highs++;
            @(negedge clk);
        end
        check(highs == 0, req, highs, 0);
    endtask

    initial begin
        #(20 * 100000);
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, outputs low
        low_window(0, 10, "R1 pulse0 after reset");
        low_window(1, 10, "R1 pulse1 after reset");

        // R2 / R4 / R6: channel 0, undivided, L=3 H=5
        cur_req = "R2";
        wr(0, 3); wr(1, 5); wr(4, 8'h01);
        run_len(0, 0, n); check(n == 5, "R2 first low after enable", n, 5);
        cur_req = "R4";
        run_len(0, 1, n); check(n == 6, "R4 high H+1", n, 6);
        run_len(0, 0, n); check(n == 4, "R4 low L+1", n, 4);
        run_len(0, 1, n); check(n == 6, "R4 repeated high", n, 6);

        // R3: stop and hold low
        cur_req = "R3";
        wr(4, 8'h00);
        @(negedge clk);
        low_window(0, 30, "R3 held low after stop");

        // R5: divide by 4, L=1 H=2
        cur_req = "R5";
        wr(0, 1); wr(1, 2); wr(4, 8'h05);
        wait_level(0, 1);
        run_len(0, 1, n); check(n == 12, "R5 div4 high", n, 12);
        run_len(0, 0, n); check(n == 8, "R5 div4 low", n, 8);
        wr(4, 8'h00);
        // R5: timebase every 3 cycles, L=0 H=1
        tb_on = 1'b1;
        wr(0, 0); wr(1, 1); wr(4, 8'h0B);
        wait_level(0, 0); wait_level(0, 1);
        run_len(0, 1, n); check(n == 6, "R5 timebase high", n, 6);
        run_len(0, 0, n); check(n == 3, "R5 timebase low", n, 3);
        wr(4, 8'h00);
        tb_on = 1'b0;

        // R7: reload change during a high phase on channel 1
        cur_req = "R7";
        wr(2, 9); wr(3, 9); wr(7, 8'hFF); wr(5, 8'h01);
        wait_level(1, 1);
        wr(3, 2);
        run_len(1, 1, n); check(n + 1 == 10, "R7 current high kept", n + 1, 10);
        run_len(1, 0, n); check(n == 10, "R7 low unchanged", n, 10);
        run_len(1, 1, n); check(n == 3, "R7 new high used", n, 3);
        check(m_lo[0] == 0, "R6 address 7 ignored", m_lo[0], 0);
        wr(5, 8'h00);
        @(negedge clk);

        // R9: chained, channel 1 enabled while channel 0 stopped
        cur_req = "R9";
        wr(2, 1); wr(3, 1); wr(5, 8'h11);
        low_window(1, 60, "R9 chained idle");

        // R8: start channel 0 as prescaler, L=0 H=0
        cur_req = "R8";
        wr(0, 0); wr(1, 0); wr(4, 8'h01);
        wait_level(1, 1);
        run_len(1, 1, n); check(n == 4, "R8 chained high", n, 4);
        run_len(1, 0, n); check(n == 4, "R8 chained low", n, 4);
        wr(6, 0);
        @(negedge clk);

        // R10: wide arrangement, L=0x0101 H=0x0002
        cur_req = "R10";
        wr(5, 8'h30); wr(0, 1); wr(2, 1); wr(1, 2); wr(3, 0);
        wr(4, 8'h01);
        low_window(0, 300, "R10 one enable only");
        wr(6, 1);
        wait_level(0, 1);
        check(pulse1 == 1'b1, "R10 pulse1 mirrors", pulse1, 1);
        run_len(0, 1, n); check(n == 3, "R10 wide high", n, 3);
        run_len(0, 0, n); check(n == 258, "R10 wide low", n, 258);
        run_len(0, 1, n); check(n == 3, "R10 wide high again", n, 3);
        wr(6, 0);
        @(negedge clk);
        low_window(1, 20, "R10 joint stop");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule